// File: doc/BRIEF.md
# Sub-Second Increment Update Handshake

This block holds a 24-bit increment for a real-time counter and moves it across to the counter side through a request/acknowledge exchange. Software writes the low sixteen bits and the high eight bits into two separate staging registers. It then sets a request bit. The counter side sees the request through a two-flop synchronizer. It loads all 24 staged bits into its increment register in one cycle and raises an acknowledge. The acknowledge returns to the register side through a second two-flop synchronizer.

Software clears the request once the acknowledge reads 1. The acknowledge then drops, which completes a four-phase exchange. While the exchange runs, the staging registers and the request bit are protected against writes that would break it. A simple counter model adds the active increment to a 32-bit accumulator on every tick.

Top module: `subsec_step_xfer`

## Requirements
- R1: After reset, every readable register reads 0, `step_o` is 0 and `acc_o` is 0.
- R2: Address 0 is the low staging register. Bits 15:0 hold increment bits 15:0, and bits 31:16 read as 0 whatever was written to them.
- R3: Address 1 is the high staging register. Bits 7:0 hold increment bits 23:16, and bits 31:8 read as 0.
- R4: Address 2 is the control register. Bit 0 is the request and can be read and written. Bit 1 is the acknowledge and is read-only, so writing it has no effect. All other bits read 0, and address 3 reads 0.
- R5: `step_o` changes only when the counter side takes a request. At that moment it loads the whole 24-bit staged value {high, low} in a single cycle.
- R6: The acknowledge rises only while the request is 1, and falls only after the request has been cleared. Each transition reaches the control register within a bounded number of cycles.
- R7: A write to the request bit is ignored while the request differs from the acknowledge.
- R8: Writes to either staging register are ignored while the request is 1. They are accepted again once the request is 0.
- R9: On each cycle with `tick` high, `acc_o` gains `step_o` modulo 2^32. Without `tick`, `acc_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Read data for `rd_addr` (combinational) |
| tick | input | 1 | Counter advance pulse |
| step_o | output | 24 | Increment in use on the counter side |
| acc_o | output | 32 | Counter accumulator |

## Verification
The assertions check the following properties on every cycle:
- `step_o` moves only when the counter side takes a request, and it then equals the staged pair.
- The acknowledge rises only under a set request and falls only under a cleared one.
- The request toggles only while it matches the acknowledge.
- The staging registers stay frozen under a pending request.
- The accumulator steps or holds according to `tick`.

Only the bench scenarios can show the rest: the field placement and zeroed upper bits seen through reads, and the ignored writes to the acknowledge bit. They also cover the end-to-end latency of both handshake phases and wrapping of the accumulator over many ticks.

// File: rtl/subsec_step_xfer.sv
module subsec_step_xfer #(
  parameter int LO_W  = 16,
  parameter int HI_W  = 8,
  parameter int ACC_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [1:0]            wr_addr,
  input  logic [31:0]           wr_data,
  input  logic [1:0]            rd_addr,
  output logic [31:0]           rd_data,
  input  logic                  tick,
  output logic [LO_W+HI_W-1:0]  step_o,
  output logic [ACC_W-1:0]      acc_o
);
  localparam int STEP_W = LO_W + HI_W;

  logic [LO_W-1:0]   lo_q;
  logic [HI_W-1:0]   hi_q;
  logic              req_q;
  logic [1:0]        req_sync;
  logic              cnt_ack;
  logic [1:0]        ack_sync;
  logic [STEP_W-1:0] step_q;
  logic [ACC_W-1:0]  acc_q;

  wire ack_seen  = ack_sync[1];
  wire req_cnt   = req_sync[1];
  wire stage_ok  = wr_en && !req_q;
  wire ctrl_ok   = wr_en && (wr_addr == 2'd2) && (req_q == ack_seen);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      req_q <= 1'b0;
    end else begin
      if (stage_ok && wr_addr == 2'd0) lo_q <= wr_data[LO_W-1:0];
      if (stage_ok && wr_addr == 2'd1) hi_q <= wr_data[HI_W-1:0];
      if (ctrl_ok) req_q <= wr_data[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_sync <= '0;
      ack_sync <= '0;
    end else begin
      req_sync <= {req_sync[0], req_q};
      ack_sync <= {ack_sync[0], cnt_ack};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_ack <= 1'b0;
      step_q  <= '0;
    end else if (req_cnt && !cnt_ack) begin
      cnt_ack <= 1'b1;
      step_q  <= {hi_q, lo_q};
    end else if (!req_cnt && cnt_ack) begin
      cnt_ack <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    acc_q <= '0;
    else if (tick) acc_q <= acc_q + ACC_W'(step_q);
  end

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = 32'(lo_q);
      2'd1:    rd_data = 32'(hi_q);
      2'd2:    rd_data = {30'd0, ack_seen, req_q};
      default: rd_data = '0;
    endcase
  end

  assign step_o = step_q;
  assign acc_o  = acc_q;
endmodule

// File: rtl/subsec_step_xfer_chk.sv
module subsec_step_xfer_chk #(
  parameter int LO_W  = 16,
  parameter int HI_W  = 8,
  parameter int ACC_W = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tick,
  input logic [LO_W-1:0]      lo_q,
  input logic [HI_W-1:0]      hi_q,
  input logic                 req_q,
  input logic                 cnt_ack,
  input logic                 ack_seen,
  input logic [LO_W+HI_W-1:0] step_o,
  input logic [ACC_W-1:0]     acc_o
);
  AST_STEP_ONLY_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(step_o) |-> $rose(cnt_ack)); // R5
  AST_STEP_WHOLE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnt_ack) |-> step_o == {hi_q, lo_q}); // R5
  AST_ACK_RISE_UNDER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_seen) |-> req_q); // R6
  AST_ACK_FALL_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_seen) |-> !req_q); // R6
  AST_REQ_SET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> !$past(ack_seen)); // R7
  AST_REQ_CLEAR_WHEN_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_q) |-> $past(ack_seen)); // R7
  AST_STAGE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> $stable(lo_q) && $stable(hi_q)); // R8
  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(acc_o)); // R9
  AST_ACC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> acc_o == $past(acc_o) + ACC_W'($past(step_o))); // R9
endmodule

bind subsec_step_xfer subsec_step_xfer_chk #(.LO_W(LO_W), .HI_W(HI_W), .ACC_W(ACC_W)) chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .lo_q(lo_q), .hi_q(hi_q),
  .req_q(req_q), .cnt_ack(cnt_ack), .ack_seen(ack_seen),
  .step_o(step_o), .acc_o(acc_o)
);

// File: tb/subsec_step_xfer_test.sv
module subsec_step_xfer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        tick = 1'b0;
  logic [23:0] step_o;
  logic [31:0] acc_o;

  int checks = 0;
  int fails = 0;
  logic [31:0] exp_acc;

  always #5 clk = ~clk;

  subsec_step_xfer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tick(tick), .step_o(step_o), .acc_o(acc_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic wait_ctrl(input string req, input logic [31:0] want);
    logic [31:0] v;
    int n = 0;
    rd(2'd2, v);
    while (v != want && n < 20) begin
      rd(2'd2, v);
      n++;
    end
    check(req, v, want);
  endtask

  task automatic run_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = 1'b1;
      exp_acc = exp_acc + {8'd0, step_o};
    end
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      check("R1 reg", v, 32'd0);
    end
    check("R1 step", {8'd0, step_o}, 32'd0);
    check("R1 acc", acc_o, 32'd0);
  endtask

  task automatic t_fields();
    logic [31:0] v;
    wr(2'd0, 32'hFFFF_ABCD);
    rd(2'd0, v); check("R2 low field", v, 32'h0000_ABCD);
    wr(2'd1, 32'h1234_56FE);
    rd(2'd1, v); check("R3 high field", v, 32'h0000_00FE);
    wr(2'd2, 32'hFFFF_FFFE);
    rd(2'd2, v); check("R4 ack read-only", v, 32'd0);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, v); check("R4 addr3 zero", v, 32'd0);
    check("R5 step untouched by staging", {8'd0, step_o}, 32'd0);
  endtask

  task automatic t_handshake();
    logic [31:0] v;
    wr(2'd2, 32'd1);
    wr(2'd2, 32'd0);
    rd(2'd2, v); check("R7 clear ignored before ack", v[0], 1'b1);
    wr(2'd0, 32'h0000_1111);
    wr(2'd1, 32'h0000_0022);
    rd(2'd0, v); check("R8 low frozen", v, 32'h0000_ABCD);
    rd(2'd1, v); check("R8 high frozen", v, 32'h0000_00FE);
    wait_ctrl("R6 ack rises", 32'd3);
    check("R5 full value loaded", {8'd0, step_o}, 32'h00FE_ABCD);
    wr(2'd2, 32'd0);
    wr(2'd2, 32'd1);
    rd(2'd2, v); check("R7 set ignored while ack high", v[0], 1'b0);
    wait_ctrl("R6 ack falls", 32'd0);
    check("R5 step kept after handshake", {8'd0, step_o}, 32'h00FE_ABCD);
    wr(2'd0, 32'h0000_5A5A);
    rd(2'd0, v); check("R8 low accepted after done", v, 32'h0000_5A5A);
  endtask

  task automatic t_accum();
    run_ticks(3);
    check("R9 three ticks", acc_o, exp_acc);
    repeat (4) @(negedge clk);
    check("R9 hold without tick", acc_o, exp_acc);
    wr(2'd0, 32'h0000_FFFF);
    wr(2'd1, 32'h0000_00FF);
    wr(2'd2, 32'd1);
    wait_ctrl("R6 second ack", 32'd3);
    check("R5 max value", {8'd0, step_o}, 32'h00FF_FFFF);
    wr(2'd2, 32'd0);
    wait_ctrl("R6 second release", 32'd0);
    run_ticks(300);
    check("R9 wrap", acc_o, exp_acc);
  endtask

  initial begin
    exp_acc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fields();
    t_handshake();
    t_accum();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1ms;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule